// File: doc/BRIEF.md
# Byte-Serial Conditional Branch Resolver

This block sits behind an instruction byte stream and resolves conditional branches one byte per cycle. Bytes arrive over a valid/ready handshake. The block recognises three kinds of branch. The first is a one-byte opcode carrying an 8-bit displacement. The second is an escape-prefixed two-byte opcode carrying a 16-bit or 32-bit displacement. The third is a jump that tests the count register for zero. For each branch it decides whether the branch is taken and produces the next instruction pointer.

The branch condition comes from a flags word supplied by the core and is chosen by the low nibble of the opcode. Both flag-testing families share that nibble encoding, so one evaluator serves both. The count-zero jump ignores the flags. It tests the low 16 or all 32 bits of the count value, as the address-size attribute selects. When the operand size is 16, the produced pointer is limited to 16 bits. Any other opcode is reported as unsupported, and no result is produced for it.

The result is held until the consumer accepts it. No flag is ever written back. The current pointer, the flags, the count value and both size attributes are sampled in the cycle the last displacement byte is accepted. The operand-size input is also sampled when the second byte of an escape-prefixed opcode is accepted, because it fixes the displacement length.

Top module: `cond_branch_resolver`

## Requirements
- R1: After a synchronous active-high reset, byteReady is 1 and resValid and unsupported are 0.
- R2: An opcode byte 0x70 to 0x7F is followed by one displacement byte. The instruction length is 2.
- R3: The low opcode nibble selects the condition. flagsIn bit 0 is CF, bit 1 is ZF, bit 2 is SF, bit 3 is OF and bit 4 is PF. The nibbles map as follows: 0 is OF; 1 is !OF; 2 is CF; 3 is !CF; 4 is ZF; 5 is !ZF; 6 is CF|ZF; 7 is !CF&!ZF; 8 is SF; 9 is !SF; A is PF; B is !PF; C is SF!=OF; D is SF==OF; E is ZF|(SF!=OF); F is !ZF&(SF==OF).
- R4: The byte 0x0F followed by 0x80 to 0x8F is followed by its displacement, least-significant byte first. The displacement is 2 bytes (length 4) when opSize32 is 0 and 4 bytes (length 6) when it is 1.
- R5: Opcode 0xE3 takes one displacement byte and ignores flagsIn. It is taken when countReg[15:0] is zero (addrSize32=0) or when all of countReg is zero (addrSize32=1).
- R6: When taken, nextIp = curIp + length + the sign-extended displacement, modulo 2^32, and resTaken is 1.
- R7: When not taken, nextIp = curIp + length and resTaken is 0.
- R8: When opSize32 is 0, nextIp[31:16] is 0 in every result.
- R9: Two cases are unsupported: an opcode byte outside 0x70-0x7F, 0x0F and 0xE3, and a 0x0F followed by a byte outside 0x80-0x8F. In either case unsupported is 1 for the cycle after that byte is accepted, no result is produced, and the block is ready for a new opcode.
- R10: resValid rises in the cycle after the last displacement byte is accepted. While resValid is 1 and resReady is 0, resValid, resTaken and nextIp hold and byteReady is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byteValid | input | 1 | Instruction byte present |
| byteData | input | 8 | Instruction byte |
| byteReady | output | 1 | Block accepts a byte this cycle |
| curIp | input | 32 | Address of the branch opcode |
| opSize32 | input | 1 | Operand size 32 (1) or 16 (0) |
| addrSize32 | input | 1 | Address size 32 (1) or 16 (0) |
| flagsIn | input | 5 | Flags word: CF, ZF, SF, OF, PF in bits 0 to 4 |
| countReg | input | 32 | Count register value |
| resValid | output | 1 | Branch result available |
| resReady | input | 1 | Consumer accepts the result |
| resTaken | output | 1 | Branch taken |
| nextIp | output | 32 | Next instruction pointer |
| unsupported | output | 1 | Pulse: opcode not handled |

## Verification
The bench aims at the sign boundaries of each displacement width: 0x80, 0x8000 and 0x80000000 must go backwards. A design that zero-extends would land far forward, and one that adds the displacement to the opcode address would be off by the length. It also sends count values with only the upper half set, such as 0x10000, under both address sizes. A design that picks the wrong width would take or skip the jump wrongly. It checks for an escape followed by a non-branch byte, which a careless decoder treats as a branch and waits for bytes that never come. It also walks all sixteen condition nibbles against flag patterns where SF and OF disagree, so that a swapped signed test shows up.

// File: rtl/cbr_pkg.sv
package cbr_pkg;
  localparam int IP_W   = 32;
  localparam int BYTE_W = 8;
  localparam int HALF_W = IP_W / 2;
  localparam int FLAG_W = 5;
  localparam int COND_W = 4;
  localparam int LEN_W  = 3;
  localparam int REM_W  = 3;

  // flag word bit positions
  localparam int F_CF = 0;
  localparam int F_ZF = 1;
  localparam int F_SF = 2;
  localparam int F_OF = 3;
  localparam int F_PF = 4;

  localparam logic [BYTE_W-1:0] OPC_ESCAPE = 8'h0F;
  localparam logic [BYTE_W-1:0] OPC_CNTZ   = 8'hE3;
  localparam logic [3:0]        HI_SHORT   = 4'h7;
  localparam logic [3:0]        HI_NEAR    = 4'h8;

  typedef enum logic [1:0] {DSZ_B1, DSZ_B2, DSZ_B4} dispSize_e;

  typedef struct packed {
    logic              latchOp;
    logic [COND_W-1:0] condSel;
    logic              countTest;
    dispSize_e         dispSize;
    logic [LEN_W-1:0]  instLen;
    logic              shiftIn;
    logic              resolve;
  } cbrStrobes_t;
endpackage

// File: rtl/cbr_cond_eval.sv
module cbr_cond_eval
  import cbr_pkg::*;
(
  input  logic [FLAG_W-1:0] flags,
  input  logic [COND_W-1:0] condSel,
  output logic              condMet
);
  logic cf, zf, sf, ofl, pf, sgnLess, base;

  always_comb begin
    cf      = flags[F_CF];
    zf      = flags[F_ZF];
    sf      = flags[F_SF];
    ofl     = flags[F_OF];
    pf      = flags[F_PF];
    sgnLess = sf ^ ofl;
    unique case (condSel[COND_W-1:1])
      3'd0:    base = ofl;
      3'd1:    base = cf;
      3'd2:    base = zf;
      3'd3:    base = cf | zf;
      3'd4:    base = sf;
      3'd5:    base = pf;
      3'd6:    base = sgnLess;
      default: base = zf | sgnLess;
    endcase
    // odd encodings test the complement of their even partner
    condMet = base ^ condSel[0];
  end
endmodule

// File: rtl/cbr_ctrl.sv
module cbr_ctrl
  import cbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              opSize32,
  input  logic              resReady,
  output logic              byteReady,
  output logic              resValid,
  output logic              unsupported,
  output cbrStrobes_t       strobes
);
  typedef enum logic [1:0] {S_IDLE, S_ESC, S_DISP, S_OUT} state_e;

  state_e           stateR, stateNx;
  logic [REM_W-1:0] remR, remNx;
  logic             unsupR, unsupNx;
  logic             accept;

  assign byteReady   = (stateR != S_OUT);
  assign resValid    = (stateR == S_OUT);
  assign unsupported = unsupR;
  assign accept      = byteValid && byteReady;

  always_comb begin
    stateNx = stateR;
    remNx   = remR;
    unsupNx = 1'b0;
    strobes = '0;
    unique case (stateR)
      S_IDLE: if (accept) begin
        if (byteData[BYTE_W-1:4] == HI_SHORT) begin
          strobes.latchOp  = 1'b1;
          strobes.condSel  = byteData[COND_W-1:0];
          strobes.dispSize = DSZ_B1;
          strobes.instLen  = LEN_W'(2);
          remNx            = REM_W'(1);
          stateNx          = S_DISP;
        end else if (byteData == OPC_CNTZ) begin
          strobes.latchOp   = 1'b1;
          strobes.countTest = 1'b1;
          strobes.dispSize  = DSZ_B1;
          strobes.instLen   = LEN_W'(2);
          remNx             = REM_W'(1);
          stateNx           = S_DISP;
        end else if (byteData == OPC_ESCAPE) begin
          stateNx = S_ESC;
        end else begin
          unsupNx = 1'b1;
        end
      end
      S_ESC: if (accept) begin
        if (byteData[BYTE_W-1:4] == HI_NEAR) begin
          strobes.latchOp  = 1'b1;
          strobes.condSel  = byteData[COND_W-1:0];
          strobes.dispSize = opSize32 ? DSZ_B4 : DSZ_B2;
          strobes.instLen  = opSize32 ? LEN_W'(6) : LEN_W'(4);
          remNx            = opSize32 ? REM_W'(4) : REM_W'(2);
          stateNx          = S_DISP;
        end else begin
          unsupNx = 1'b1;
          stateNx = S_IDLE;
        end
      end
      S_DISP: if (accept) begin
        strobes.shiftIn = 1'b1;
        remNx           = remR - REM_W'(1);
        if (remR == REM_W'(1)) begin
          strobes.resolve = 1'b1;
          stateNx         = S_OUT;
        end
      end
      default: if (resReady) stateNx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateR <= S_IDLE;
      remR   <= '0;
      unsupR <= 1'b0;
    end else begin
      stateR <= stateNx;
      remR   <= remNx;
      unsupR <= unsupNx;
    end
  end
endmodule

// File: rtl/cbr_dpath.sv
module cbr_dpath
  import cbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  cbrStrobes_t       strobes,
  input  logic [BYTE_W-1:0] byteData,
  input  logic [IP_W-1:0]   curIp,
  input  logic              opSize32,
  input  logic              addrSize32,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [IP_W-1:0]   countReg,
  output logic [IP_W-1:0]   nextIp,
  output logic              resTaken
);
  logic [COND_W-1:0]      condR;
  logic                   countTestR;
  dispSize_e              sizeR;
  logic [LEN_W-1:0]       lenR;
  logic [IP_W-1:0]        dispR, dispFull, fallIp, tgtIp, rawIp, resIp;
  logic signed [IP_W-1:0] dispExt;
  logic [5:0]             shiftAmt;
  logic                   flagMet, countZero, met;

  cbr_cond_eval u_eval (
    .flags   (flagsIn),
    .condSel (condR),
    .condMet (flagMet)
  );

  always_comb begin
    dispFull = {byteData, dispR[IP_W-1:BYTE_W]};
    unique case (sizeR)
      DSZ_B1:  shiftAmt = 6'(IP_W - BYTE_W);
      DSZ_B2:  shiftAmt = 6'(IP_W - 2 * BYTE_W);
      default: shiftAmt = 6'd0;
    endcase
    dispExt   = $signed(dispFull) >>> shiftAmt;
    fallIp    = curIp + IP_W'(lenR);
    tgtIp     = fallIp + $unsigned(dispExt);
    countZero = addrSize32 ? (countReg == '0) : (countReg[HALF_W-1:0] == '0);
    met       = countTestR ? countZero : flagMet;
    rawIp     = met ? tgtIp : fallIp;
    resIp     = opSize32 ? rawIp : {{HALF_W{1'b0}}, rawIp[HALF_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      condR      <= '0;
      countTestR <= 1'b0;
      sizeR      <= DSZ_B1;
      lenR       <= '0;
      dispR      <= '0;
      nextIp     <= '0;
      resTaken   <= 1'b0;
    end else begin
      if (strobes.latchOp) begin
        condR      <= strobes.condSel;
        countTestR <= strobes.countTest;
        sizeR      <= strobes.dispSize;
        lenR       <= strobes.instLen;
        dispR      <= '0;
      end else if (strobes.shiftIn) begin
        dispR <= dispFull;
      end
      if (strobes.resolve) begin
        nextIp   <= resIp;
        resTaken <= met;
      end
    end
  end
endmodule

// File: rtl/cond_branch_resolver.sv
module cond_branch_resolver
  import cbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              byteValid,
  input  logic [BYTE_W-1:0] byteData,
  output logic              byteReady,
  input  logic [IP_W-1:0]   curIp,
  input  logic              opSize32,
  input  logic              addrSize32,
  input  logic [FLAG_W-1:0] flagsIn,
  input  logic [IP_W-1:0]   countReg,
  output logic              resValid,
  input  logic              resReady,
  output logic              resTaken,
  output logic [IP_W-1:0]   nextIp,
  output logic              unsupported
);
  cbrStrobes_t strobes;

  cbr_ctrl u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .byteValid   (byteValid),
    .byteData    (byteData),
    .opSize32    (opSize32),
    .resReady    (resReady),
    .byteReady   (byteReady),
    .resValid    (resValid),
    .unsupported (unsupported),
    .strobes     (strobes)
  );

  cbr_dpath u_dpath (
    .clk        (clk),
    .rst        (rst),
    .strobes    (strobes),
    .byteData   (byteData),
    .curIp      (curIp),
    .opSize32   (opSize32),
    .addrSize32 (addrSize32),
    .flagsIn    (flagsIn),
    .countReg   (countReg),
    .nextIp     (nextIp),
    .resTaken   (resTaken)
  );
endmodule

// File: rtl/cbr_checker.sv
module cbr_checker
  import cbr_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            byteValid,
  input logic            byteReady,
  input logic            opSize32,
  input logic            resValid,
  input logic            resReady,
  input logic            resTaken,
  input logic [IP_W-1:0] nextIp,
  input logic            unsupported
);
  // R10
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (resValid && !resReady) |=> (resValid && $stable(nextIp) && $stable(resTaken)));

  // R8
  narrow_ip_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(resValid) && !$past(opSize32)) |-> (nextIp[IP_W-1:HALF_W] == '0));

  // R10
  result_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(resValid) |-> $past(byteValid && byteReady));

  // R9
  unsup_after_byte_chk: assert property (@(posedge clk) disable iff (rst)
    unsupported |-> ($past(byteValid && byteReady) && !resValid));
endmodule

bind cond_branch_resolver cbr_checker u_cbr_checker (
  .clk         (clk),
  .rst         (rst),
  .byteValid   (byteValid),
  .byteReady   (byteReady),
  .opSize32    (opSize32),
  .resValid    (resValid),
  .resReady    (resReady),
  .resTaken    (resTaken),
  .nextIp      (nextIp),
  .unsupported (unsupported)
);

// File: tb/cond_branch_resolver_bench.sv
module cond_branch_resolver_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        byteReady;
  logic [31:0] curIp = '0;
  logic        opSize32 = 1'b1;
  logic        addrSize32 = 1'b1;
  logic [4:0]  flagsIn = '0;
  logic [31:0] countReg = '0;
  logic        resValid;
  logic        resReady = 1'b0;
  logic        resTaken;
  logic [31:0] nextIp;
  logic        unsupported;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  cond_branch_resolver u_cond_branch_resolver (
    .clk(clk), .rst(rst), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .curIp(curIp), .opSize32(opSize32),
    .addrSize32(addrSize32), .flagsIn(flagsIn), .countReg(countReg),
    .resValid(resValid), .resReady(resReady), .resTaken(resTaken),
    .nextIp(nextIp), .unsupported(unsupported)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // condition table, written per nibble; flags: 0 CF,1 ZF,2 SF,3 OF,4 PF
  function automatic logic expCond(input logic [3:0] c, input logic [4:0] f);
    logic cf, zf, sf, of_, pf;
    cf = f[0]; zf = f[1]; sf = f[2]; of_ = f[3]; pf = f[4];
    case (c)
      4'h0: return of_;
      4'h1: return !of_;
      4'h2: return cf;
      4'h3: return !cf;
      4'h4: return zf;
      4'h5: return !zf;
      4'h6: return cf || zf;
      4'h7: return !cf && !zf;
      4'h8: return sf;
      4'h9: return !sf;
      4'hA: return pf;
      4'hB: return !pf;
      4'hC: return sf != of_;
      4'hD: return sf == of_;
      4'hE: return zf || (sf != of_);
      default: return !zf && (sf == of_);
    endcase
  endfunction

  task automatic sendByte(input logic [7:0] b);
    byteData  = b;
    byteValid = 1'b1;
    while (!byteReady) @(negedge clk);
    @(negedge clk);
    byteValid = 1'b0;
  endtask

  // kind: 0 short, 1 near, 2 count-zero
  task automatic runInstr(input int kind, input logic [3:0] cnd, input logic [31:0] disp,
                          input logic [31:0] ip, input logic op32, input logic as32,
                          input logic [4:0] fl, input logic [31:0] cnt, input string req);
    logic [31:0] sext, fall, expIp;
    logic        expTk;
    int          len, nb;
    logic [31:0] heldIp;
    int          hold;
    curIp = ip; opSize32 = op32; addrSize32 = as32; flagsIn = fl; countReg = cnt;
    if (kind == 1) begin
      nb  = op32 ? 4 : 2;
      len = op32 ? 6 : 4;
      sext = op32 ? disp : {{16{disp[15]}}, disp[15:0]};
    end else begin
      nb = 1; len = 2;
      sext = {{24{disp[7]}}, disp[7:0]};
    end
    if (kind == 2) expTk = as32 ? (cnt == 0) : (cnt[15:0] == 0);
    else           expTk = expCond(cnd, fl);
    fall  = ip + 32'(len);
    expIp = expTk ? fall + sext : fall;
    if (!op32) expIp[31:16] = '0;
    if (kind == 0)      sendByte({4'h7, cnd});
    else if (kind == 2) sendByte(8'hE3);
    else begin
      sendByte(8'h0F);
      sendByte({4'h8, cnd});
    end
    for (int i = 0; i < nb; i++) sendByte(disp[8*i +: 8]);
    check(resValid === 1'b1, "R10 valid", {31'b0, resValid}, 32'd1);
    check(resTaken === expTk, {req, " taken"}, {31'b0, resTaken}, {31'b0, expTk});
    check(nextIp === expIp, {req, " ip"}, nextIp, expIp);
    if (!op32) check(nextIp[31:16] === 16'h0, "R8", nextIp, expIp);
    heldIp = nextIp;
    hold = int'($urandom_range(0, 2));
    for (int h = 0; h < hold; h++) begin
      flagsIn = ~flagsIn; curIp = curIp + 32'd77;
      @(negedge clk);
      check(resValid === 1'b1 && byteReady === 1'b0 && nextIp === heldIp,
            "R10 hold", nextIp, heldIp);
    end
    resReady = 1'b1;
    @(negedge clk);
    resReady = 1'b0;
    check(resValid === 1'b0 && byteReady === 1'b1, "R10 release", {31'b0, resValid}, 32'd0);
  endtask

  task automatic runBad(input logic esc, input logic [7:0] b);
    if (esc) sendByte(8'h0F);
    sendByte(b);
    check(unsupported === 1'b1 && resValid === 1'b0, "R9 pulse", {31'b0, unsupported}, 32'd1);
    @(negedge clk);
    check(unsupported === 1'b0 && byteReady === 1'b1 && resValid === 1'b0,
          "R9 idle", {31'b0, unsupported}, 32'd0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(byteReady === 1'b1 && resValid === 1'b0 && unsupported === 1'b0,
          "R1", {29'b0, byteReady, resValid, unsupported}, 32'h4);

    // R3: every nibble against several flag patterns
    for (int c = 0; c < 16; c++)
      for (int p = 0; p < 6; p++) begin
        logic [4:0] fp;
        case (p)
          0: fp = 5'b00000; 1: fp = 5'b11111; 2: fp = 5'b00100;
          3: fp = 5'b01000; 4: fp = 5'b00011; default: fp = 5'b10001;
        endcase
        runInstr(0, 4'(c), 32'h10, 32'h1000, 1'b1, 1'b1, fp, 32'd5, "R3");
      end

    // R2 and R6: 8-bit sign boundaries
    runInstr(0, 4'h4, 32'h80, 32'h2000, 1'b1, 1'b1, 5'b00010, 0, "R6 b80");
    runInstr(0, 4'h4, 32'h7F, 32'h2000, 1'b1, 1'b1, 5'b00010, 0, "R2 b7F");
    runInstr(0, 4'h5, 32'hFE, 32'h0, 1'b1, 1'b1, 5'b00000, 0, "R6 wrap");
    // R4 and R6: near boundaries
    runInstr(1, 4'h4, 32'h8000, 32'h30000, 1'b0, 1'b1, 5'b00010, 0, "R4 n16");
    runInstr(1, 4'h4, 32'h80000000, 32'h100, 1'b1, 1'b1, 5'b00010, 0, "R4 n32");
    runInstr(1, 4'h5, 32'h12345678, 32'h100, 1'b1, 1'b1, 5'b00010, 0, "R7 near");
    // R8: fall-through and target under operand size 16
    runInstr(0, 4'h5, 32'h10, 32'hABCDFFFF, 1'b0, 1'b1, 5'b00010, 0, "R8 fall");
    runInstr(0, 4'h4, 32'h10, 32'hABCDFFF8, 1'b0, 1'b1, 5'b00010, 0, "R8 tgt");
    // R5: count widths, flags ignored
    runInstr(2, 4'h0, 32'h20, 32'h500, 1'b1, 1'b0, 5'b11111, 32'h10000, "R5 as16");
    runInstr(2, 4'h0, 32'h20, 32'h500, 1'b1, 1'b1, 5'b11111, 32'h10000, "R5 as32");
    runInstr(2, 4'h0, 32'hF0, 32'h500, 1'b1, 1'b1, 5'b00000, 32'h0, "R5 zero");
    runInstr(2, 4'h0, 32'hF0, 32'h500, 1'b1, 1'b0, 5'b00000, 32'h1, "R5 one");

    // R9: unsupported opcodes
    runBad(1'b0, 8'h90);
    runBad(1'b0, 8'hE2);
    runBad(1'b1, 8'h7F);
    runBad(1'b1, 8'h0F);
    runBad(1'b1, 8'h90);
    runInstr(0, 4'h4, 32'h03, 32'h40, 1'b1, 1'b1, 5'b00010, 0, "R9 recover");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k;
      logic [31:0] cv;
      k  = int'($urandom_range(0, 2));
      cv = ($urandom_range(0, 3) == 0) ? 32'h0 :
           ($urandom_range(0, 2) == 0) ? ($urandom() & 32'hFFFF0000) : $urandom();
      if ($urandom_range(0, 7) == 0) runBad(1'($urandom_range(0, 1)), 8'h90 + 8'($urandom_range(0, 15)));
      runInstr(k, 4'($urandom_range(0, 15)), $urandom(), $urandom(),
               1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
               5'($urandom_range(0, 31)), cv,
               (k == 0) ? "R2 rnd" : (k == 1) ? "R4 rnd" : "R5 rnd");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule